// File: doc/BRIEF.md
# SFDP Discovery Checker

At power-up a serial flash controller has to learn whether the attached device is usable and how large it is. This block runs that discovery once per start pulse. It reads the three-byte JEDEC identity, clears factory write protection on devices whose first identity byte is 0xBF, and waits for the device to report idle. It then reads the serial flash discoverable parameters header. From that header it locates the basic parameter table and reads it, checks a fixed set of fields, and turns the stored density into a capacity in bytes.

The block does not shift bits itself. It hands one command at a time to a neighbouring command framer. Each command gives an opcode, an address length, an address and a return byte count. The framer streams the returned bytes back and then pulses a completion signal. The result stays on the outputs until the next start pulse.

Top module: `sfdp_probe`

## Requirements
- R1: After reset, busy, result_valid, pass, capacity and fr_start are all zero.
- R2: The first command of a run is opcode 0x9F with address length 0 and 3 return bytes.
- R3: If identity byte 0 is 0xBF, the next commands are opcode 0x06 and then opcode 0x98, both with address length 0 and 0 return bytes. For any other identity byte 0, neither command is sent.
- R4: Before the header read, status is read with opcode 0x05 (address length 0, 1 return byte) until bit 0 of the returned byte is 0. After POLL_LIMIT reads that all have bit 0 set, the run ends with pass=0 and no header read.
- R5: The header is read with opcode 0x5A, address length 4, address 0 and 16 return bytes.
- R6: The header is accepted only if bytes 0..3 are 0x53,0x46,0x44,0x50, byte 5 is 0x01, byte 8 is 0x00 and byte 10 is 0x01. Otherwise the run ends with pass=0 and no table read.
- R7: The table is read with opcode 0x5A, address length 4, 8 return bytes and address {hdr[14],hdr[13],hdr[12],8'h00}.
- R8: The run fails unless table byte 0 bits 1:0 are 2'b01 and table byte 1 is 0x20.
- R9: The run fails if table byte 2 bit 2 is set or if table byte 7 bit 7 is set.
- R10: On a pass, capacity equals {tbl[7],tbl[6],tbl[5],tbl[4]}/8 + 1. On a fail, capacity is 0.
- R11: busy is high from the cycle after start until result_valid rises. result_valid is cleared by start. pass, capacity and result_valid hold while the block is idle.
- R12: A start pulse while busy is ignored and sends no second identity read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse to begin discovery |
| busy | output | 1 | Discovery in progress |
| result_valid | output | 1 | Result available, held until next start |
| pass | output | 1 | Device accepted |
| capacity | output | 32 | Device size in bytes, 0 on failure |
| fr_start | output | 1 | One-cycle command request to the framer |
| fr_op | output | 8 | Command opcode |
| fr_addr_len | output | 3 | Address bytes to send (0 or 4) |
| fr_addr | output | 32 | Address, sent most significant byte first |
| fr_rx_len | output | 5 | Bytes to read back |
| fr_done | input | 1 | Command finished; comes after the last byte |
| fr_rx_valid | input | 1 | Returned byte strobe |
| fr_rx_data | input | 8 | Returned byte |

## Verification
The hardest paths to reach are the status-poll timeout and the protection-clear branch. Both depend on what a device answers, not on anything the host drives. The bench's framer model answers each status read with the busy bit set for a chosen number of reads, and it can keep it set for good, so both the late-idle case and the timeout are reached. It can also report 0xBF as the first identity byte. The bench logs every command the block issues, so the order of commands and each skipped read are checked directly.

// File: rtl/sfdp_probe_pkg.sv
// Shared constants and state type for the discovery checker.
package sfdp_probe_pkg;
    localparam logic [7:0] OP_ID      = 8'h9F;
    localparam logic [7:0] OP_WREN    = 8'h06;
    localparam logic [7:0] OP_UNLOCK  = 8'h98;
    localparam logic [7:0] OP_STATUS  = 8'h05;
    localparam logic [7:0] OP_SFDP    = 8'h5A;
    localparam logic [7:0] ID_LOCKED  = 8'hBF;
    localparam logic [7:0] ERASE_4K   = 8'h20;
    localparam int         HDR_BYTES  = 16;
    localparam int         TBL_BYTES  = 8;
    localparam int         ID_BYTES   = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ID, ST_WREN, ST_UNLOCK, ST_POLL, ST_HDR, ST_TBL
    } probe_state_t;
endpackage

// File: rtl/sfdp_byte_store.sv
// Capture buffer: holds the bytes returned by the most recent command.
// Assumes the write index restarts on each framer request, and bytes
// arrive in order. Bytes past the count of the current command are kept.
module sfdp_byte_store #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic                 wr_en,
    input  logic [7:0]           wr_data,
    output logic [DEPTH*8-1:0]   bytes_flat
);
    logic [IDX_W-1:0] idx;
    logic [7:0]       mem [DEPTH];

    // Write pointer: restart per command, advance per received byte.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) idx <= '0;
        else if (wr_en)        idx <= idx + 1'b1;
    end

    // Storage cells, one per byte lane.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)                            mem[g] <= '0;
            else if (wr_en && idx == IDX_W'(g))    mem[g] <= wr_data;
        end
        assign bytes_flat[8*g +: 8] = mem[g];
    end
endmodule

// File: rtl/sfdp_field_check.sv
// Combinational field checks over the captured bytes: header signature
// and version, table erase and addressing fields, capacity and table pointer.
// Assumes header bytes 12..14 survive the table read (the table is shorter).
module sfdp_field_check
    import sfdp_probe_pkg::*;
#(
    parameter int CAP_W = 32
) (
    input  logic [HDR_BYTES*8-1:0] b,
    output logic                   hdr_ok,
    output logic                   tbl_ok,
    output logic [31:0]            tbl_addr,
    output logic [CAP_W-1:0]       cap_bytes
);
    logic [7:0]  by [HDR_BYTES];
    logic [31:0] density;

    for (genvar g = 0; g < HDR_BYTES; g++) begin : g_split
        assign by[g] = b[8*g +: 8];
    end

    // Header: signature text, version and first parameter header id.
    always_comb begin
        hdr_ok = (by[0] == 8'h53) && (by[1] == 8'h46) && (by[2] == 8'h44)
              && (by[3] == 8'h50) && (by[5] == 8'h01) && (by[8] == 8'h00)
              && (by[10] == 8'h01);
    end

    // Table: 4 KiB erase support and 3-byte addressing only.
    always_comb begin
        tbl_ok = (by[0][1:0] == 2'b01) && (by[1] == ERASE_4K)
              && !by[2][2] && !by[7][7];
    end

    // Pointer and density assembly from little-endian fields.
    assign tbl_addr  = {by[14], by[13], by[12], 8'h00};
    assign density   = {by[7], by[6], by[5], by[4]};
    assign cap_bytes = CAP_W'((density >> 3) + 32'd1);
endmodule

// File: rtl/sfdp_probe_seq.sv
// Discovery sequencer: issues one framer command per state, waits for its
// completion, branches on captured bytes and latches the final result.
// Assumes fr_done arrives at least one cycle after the request and after
// the last returned byte.
module sfdp_probe_seq
    import sfdp_probe_pkg::*;
#(
    parameter int POLL_LIMIT = 8,
    parameter int CAP_W      = 32,
    localparam int POLL_W    = $clog2(POLL_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       byte0,
    input  logic             hdr_ok,
    input  logic             tbl_ok,
    input  logic [31:0]      tbl_addr,
    input  logic [CAP_W-1:0] cap_in,
    input  logic             fr_done,
    output logic             busy,
    output logic             result_valid,
    output logic             pass,
    output logic [CAP_W-1:0] capacity,
    output logic             fr_start,
    output logic [7:0]       fr_op,
    output logic [2:0]       fr_addr_len,
    output logic [31:0]      fr_addr,
    output logic [4:0]       fr_rx_len
);
    probe_state_t      state;
    logic              issued;
    logic [POLL_W-1:0] polls;

    assign busy     = (state != ST_IDLE);
    assign fr_start = busy && !issued;

    // Command fields for the current state.
    always_comb begin
        fr_op = OP_ID; fr_addr_len = 3'd0; fr_addr = '0; fr_rx_len = '0;
        case (state)
            ST_ID:     fr_rx_len = 5'(ID_BYTES);
            ST_WREN:   fr_op = OP_WREN;
            ST_UNLOCK: fr_op = OP_UNLOCK;
            ST_POLL:   begin fr_op = OP_STATUS; fr_rx_len = 5'd1; end
            ST_HDR:    begin fr_op = OP_SFDP; fr_addr_len = 3'd4;
                             fr_rx_len = 5'(HDR_BYTES); end
            ST_TBL:    begin fr_op = OP_SFDP; fr_addr_len = 3'd4;
                             fr_addr = tbl_addr; fr_rx_len = 5'(TBL_BYTES); end
            default:   ;
        endcase
    end

    // State walk, retry count and result latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; issued <= 1'b0; polls <= '0;
            result_valid <= 1'b0; pass <= 1'b0; capacity <= '0;
        end else begin
            if (fr_start) issued <= 1'b1;
            if (fr_done)  issued <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_ID; polls <= '0;
                    result_valid <= 1'b0; pass <= 1'b0; capacity <= '0;
                end
                ST_ID: if (fr_done)
                    state <= (byte0 == ID_LOCKED) ? ST_WREN : ST_POLL;
                ST_WREN:   if (fr_done) state <= ST_UNLOCK;
                ST_UNLOCK: if (fr_done) state <= ST_POLL;
                ST_POLL: if (fr_done) begin
                    if (!byte0[0]) state <= ST_HDR;
                    else if (polls == POLL_W'(POLL_LIMIT - 1)) begin
                        state <= ST_IDLE; result_valid <= 1'b1;
                    end else polls <= polls + 1'b1;
                end
                ST_HDR: if (fr_done) begin
                    if (hdr_ok) state <= ST_TBL;
                    else begin state <= ST_IDLE; result_valid <= 1'b1; end
                end
                ST_TBL: if (fr_done) begin
                    state <= ST_IDLE; result_valid <= 1'b1;
                    pass <= tbl_ok; capacity <= tbl_ok ? cap_in : '0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sfdp_probe.sv
// Top of the discovery checker: sequencer, capture buffer and field checks.
// Assumes a command framer that samples the command fields while fr_start
// is high and returns bytes in order before pulsing fr_done.
module sfdp_probe
    import sfdp_probe_pkg::*;
#(
    parameter int POLL_LIMIT = 8,
    parameter int CAP_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             result_valid,
    output logic             pass,
    output logic [CAP_W-1:0] capacity,
    output logic             fr_start,
    output logic [7:0]       fr_op,
    output logic [2:0]       fr_addr_len,
    output logic [31:0]      fr_addr,
    output logic [4:0]       fr_rx_len,
    input  logic             fr_done,
    input  logic             fr_rx_valid,
    input  logic [7:0]       fr_rx_data
);
    logic [HDR_BYTES*8-1:0] bytes_flat;
    logic                   hdr_ok, tbl_ok;
    logic [31:0]            tbl_addr;
    logic [CAP_W-1:0]       cap_bytes;

    sfdp_byte_store #(.DEPTH(HDR_BYTES)) i_store (
        .clk(clk), .rst_n(rst_n), .restart(fr_start),
        .wr_en(fr_rx_valid), .wr_data(fr_rx_data), .bytes_flat(bytes_flat));

    sfdp_field_check #(.CAP_W(CAP_W)) i_check (
        .b(bytes_flat), .hdr_ok(hdr_ok), .tbl_ok(tbl_ok),
        .tbl_addr(tbl_addr), .cap_bytes(cap_bytes));

    sfdp_probe_seq #(.POLL_LIMIT(POLL_LIMIT), .CAP_W(CAP_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .byte0(bytes_flat[7:0]),
        .hdr_ok(hdr_ok), .tbl_ok(tbl_ok), .tbl_addr(tbl_addr),
        .cap_in(cap_bytes), .fr_done(fr_done), .busy(busy),
        .result_valid(result_valid), .pass(pass), .capacity(capacity),
        .fr_start(fr_start), .fr_op(fr_op), .fr_addr_len(fr_addr_len),
        .fr_addr(fr_addr), .fr_rx_len(fr_rx_len));
endmodule

// File: rtl/sfdp_probe_chk.sv
// Property checker for the discovery checker, bound to its top.
module sfdp_probe_chk #(
    parameter int CAP_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             result_valid,
    input logic             pass,
    input logic [CAP_W-1:0] capacity,
    input logic             fr_start,
    input logic [7:0]       fr_op,
    input logic [2:0]       fr_addr_len,
    input logic [31:0]      fr_addr,
    input logic [4:0]       fr_rx_len
);
    p_id_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fr_start && fr_op == 8'h9F |-> fr_addr_len == 3'd0 && fr_rx_len == 5'd3);
    p_hdr_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fr_start && fr_op == 8'h5A && fr_rx_len == 5'd16 |-> fr_addr_len == 3'd4 && fr_addr == 32'd0);
    p_tbl_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fr_start && fr_op == 8'h5A && fr_rx_len == 5'd8 |-> fr_addr_len == 3'd4 && fr_addr[7:0] == 8'h00);
    p_fail_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid && !pass |-> capacity == '0);
    p_cmd_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fr_start |-> busy);
    p_valid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> !busy);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(pass) && $stable(capacity) && $stable(result_valid));
    p_single_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fr_start |=> !fr_start);
endmodule

bind sfdp_probe sfdp_probe_chk #(.CAP_W(CAP_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .result_valid(result_valid), .pass(pass), .capacity(capacity),
    .fr_start(fr_start), .fr_op(fr_op), .fr_addr_len(fr_addr_len),
    .fr_addr(fr_addr), .fr_rx_len(fr_rx_len));

// File: tb/test_sfdp_probe.sv
// Directed bench with a framer model that logs every command and answers
// from programmable identity, status, header and table contents.
module test_sfdp_probe;
    localparam int CLK_PERIOD = 10;
    localparam int POLL_N     = 8;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic busy, result_valid, pass, fr_start, fr_done, fr_rx_valid;
    logic [31:0] capacity, fr_addr;
    logic [7:0]  fr_op, fr_rx_data;
    logic [2:0]  fr_addr_len;
    logic [4:0]  fr_rx_len;

    int errors = 0, checks = 0;
    logic [7:0]  id_b [3];
    logic [7:0]  hdr [16];
    logic [7:0]  tbl [8];
    int          busy_polls, n_status, n_log;
    logic [7:0]  log_op [32];
    logic [2:0]  log_al [32];
    logic [31:0] log_ad [32];
    logic [4:0]  log_rl [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    sfdp_probe #(.POLL_LIMIT(POLL_N)) i_sfdp_probe (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .result_valid(result_valid), .pass(pass), .capacity(capacity),
        .fr_start(fr_start), .fr_op(fr_op), .fr_addr_len(fr_addr_len),
        .fr_addr(fr_addr), .fr_rx_len(fr_rx_len), .fr_done(fr_done),
        .fr_rx_valid(fr_rx_valid), .fr_rx_data(fr_rx_data));

    function automatic logic [31:0] exp_tbl_addr();
        return {hdr[14], hdr[13], hdr[12], 8'h00};
    endfunction

    // Framer model: answers one command at a time.
    initial begin
        logic [7:0] op; logic [31:0] ad; int len; logic [7:0] st;
        fr_done = 1'b0; fr_rx_valid = 1'b0; fr_rx_data = '0;
        forever begin
            @(negedge clk);
            fr_done = 1'b0;
            if (fr_start === 1'b1) begin
                op = fr_op; ad = fr_addr; len = int'(fr_rx_len);
                if (n_log < 32) begin
                    log_op[n_log] = fr_op; log_al[n_log] = fr_addr_len;
                    log_ad[n_log] = fr_addr; log_rl[n_log] = fr_rx_len;
                end
                n_log++;
                st = (n_status < busy_polls) ? 8'h03 : 8'h02;
                if (op == 8'h05) n_status++;
                @(negedge clk);
                for (int k = 0; k < len; k++) begin
                    fr_rx_valid = 1'b1;
                    if (op == 8'h9F)      fr_rx_data = (k < 3) ? id_b[k] : 8'h00;
                    else if (op == 8'h05) fr_rx_data = st;
                    else if (op == 8'h5A && ad == 32'd0) fr_rx_data = hdr[k];
                    else if (op == 8'h5A && ad == exp_tbl_addr() && k < 8) fr_rx_data = tbl[k];
                    else fr_rx_data = 8'h00;
                    @(negedge clk);
                end
                fr_rx_valid = 1'b0;
                fr_done = 1'b1;
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_good();
        id_b = '{8'hC2, 8'h28, 8'h15};
        hdr  = '{8'h53, 8'h46, 8'h44, 8'h50, 8'h06, 8'h01, 8'h01, 8'hFF,
                 8'h00, 8'h06, 8'h01, 8'h10, 8'h30, 8'h00, 8'h00, 8'hFF};
        tbl  = '{8'hE5, 8'h20, 8'hF1, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00};
        busy_polls = 0;
    endtask

    task automatic run_probe();
        n_log = 0; n_status = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R11 busy after start", 32'(busy), 32'd1);
        check("R11 valid cleared by start", 32'(result_valid), 32'd0);
        for (int i = 0; i < 3000 && !result_valid; i++) @(negedge clk);
        check("R11 done, not busy", 32'(busy), 32'd0);
    endtask

    task automatic check_cmd(string req, int i, logic [7:0] op, logic [2:0] al,
                             logic [31:0] ad, logic [4:0] rl);
        check(req, {log_op[i], 5'd0, log_al[i], 11'd0, log_rl[i]},
                   {op, 5'd0, al, 11'd0, rl});
        check(req, log_ad[i], ad);
    endtask

    task automatic t_reset();
        check("R1 busy", 32'(busy), 0);
        check("R1 valid", 32'(result_valid), 0);
        check("R1 pass", 32'(pass), 0);
        check("R1 capacity", capacity, 0);
        check("R1 fr_start", 32'(fr_start), 0);
    endtask

    task automatic t_normal();
        set_good(); run_probe();
        check("R2 log count", 32'(n_log), 4);
        check_cmd("R2 id cmd", 0, 8'h9F, 3'd0, 0, 5'd3);
        check_cmd("R3 no unlock, status next", 1, 8'h05, 3'd0, 0, 5'd1);
        check_cmd("R5 header cmd", 2, 8'h5A, 3'd4, 0, 5'd16);
        check_cmd("R7 table cmd", 3, 8'h5A, 3'd4, 32'h0000_3000, 5'd8);
        check("R10 pass", 32'(pass), 1);
        check("R10 capacity", capacity, 32'h0020_0000);
    endtask

    task automatic t_unlock();
        set_good(); id_b[0] = 8'hBF; run_probe();
        check("R3 log count", 32'(n_log), 6);
        check_cmd("R3 write enable", 1, 8'h06, 3'd0, 0, 5'd0);
        check_cmd("R3 unlock", 2, 8'h98, 3'd0, 0, 5'd0);
        check_cmd("R3 then status", 3, 8'h05, 3'd0, 0, 5'd1);
        check("R3 pass", 32'(pass), 1);
    endtask

    task automatic t_late_idle();
        set_good(); busy_polls = 3; run_probe();
        check("R4 status reads", 32'(n_status), 4);
        check("R4 pass after idle", 32'(pass), 1);
    endtask

    task automatic t_poll_timeout();
        set_good(); busy_polls = 1000; run_probe();
        check("R4 reads to limit", 32'(n_status), POLL_N);
        check("R4 no header read", 32'(n_log), POLL_N + 1);
        check("R4 fail", 32'(pass), 0);
        check("R10 fail capacity", capacity, 0);
    endtask

    task automatic t_bad_header(int idx, logic [7:0] v);
        set_good(); hdr[idx] = v; run_probe();
        check($sformatf("R6 byte %0d fail", idx), 32'(pass), 0);
        check($sformatf("R6 byte %0d no table read", idx), 32'(n_log), 3);
        check("R6 valid", 32'(result_valid), 1);
    endtask

    task automatic t_bad_table(string req, int idx, logic [7:0] v);
        set_good(); tbl[idx] = v; run_probe();
        check(req, 32'(pass), 0);
        check(req, capacity, 0);
    endtask

    task automatic t_capacity();
        set_good();
        hdr[12] = 8'h10; hdr[13] = 8'h02; hdr[14] = 8'h01;
        tbl[4] = 8'hFF; tbl[5] = 8'hFF; tbl[6] = 8'hFF; tbl[7] = 8'h7F;
        run_probe();
        check_cmd("R7 pointer bytes", 3, 8'h5A, 3'd4, 32'h0102_1000, 5'd8);
        check("R10 large capacity", capacity, 32'h1000_0000);
        check("R10 pass", 32'(pass), 1);
    endtask

    task automatic t_hold_and_ignore();
        set_good(); n_log = 0; n_status = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        for (int i = 0; i < 3000 && !result_valid; i++) @(negedge clk);
        check("R12 one id read", 32'(n_log), 4);
        check("R12 pass", 32'(pass), 1);
        repeat (20) @(negedge clk);
        check("R11 valid held", 32'(result_valid), 1);
        check("R11 capacity held", capacity, 32'h0020_0000);
        check("R11 no commands while idle", 32'(n_log), 4);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R11 watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        n_log = 0; n_status = 0; busy_polls = 0;
        set_good();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_unlock();
        t_late_idle();
        t_poll_timeout();
        t_bad_header(2, 8'h58);
        t_bad_header(5, 8'h02);
        t_bad_header(8, 8'h01);
        t_bad_header(10, 8'h00);
        t_bad_table("R8 erase type bits", 0, 8'hE6);
        t_bad_table("R8 erase opcode", 1, 8'hD8);
        t_bad_table("R9 four-byte address support", 2, 8'hF5);
        t_bad_table("R9 density high bit", 7, 8'h80);
        t_capacity();
        t_hold_and_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule